// File: doc/BRIEF.md
# Serial Real-Time Clock Register Slave

This block is the device end of a three-wire serial link (chip enable, serial clock, bidirectional data split into `sdi_i`/`sdo_o`/`sdo_en_o`). A host raises chip enable and shifts in a command byte, least-significant bit first. The command selects one register or one RAM byte, or a burst over the clock group or over the RAM. It also selects read or write. Write data follows the command. Read data is shifted out by the block, one bit after each falling serial-clock edge.

Inside, the block keeps seconds, minutes, hours, date, month, day of week and year as BCD registers. It also holds a control byte whose top bit is a write lock, a trickle-charge setting byte, and a small scratch RAM. A one-cycle `tick_i` pulse, nominally once per second, advances the calendar. The advance handles 12/24-hour formats, month lengths and leap years. Setting the halt bit in the seconds register freezes the calendar. The serial lines are sampled with the system clock, so the serial clock must be much slower than `clk_i`.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset, the registers hold these values, and `sdo_en_o` and `trickle_en_o` are low.

  | Register | Value |
  |---|---|
  | seconds | 0x80 (halted) |
  | minutes, hours, year | 0x00 |
  | date, month, day of week | 0x01 |
  | control | 0x80 (locked) |
  | trickle | 0x5C |

- R2: Command byte format:
  - Bit 7 must be 1. A command with bit 7 at 0 is ignored until chip enable drops.
  - Bit 6 selects RAM (1) or the clock group (0).
  - Bits 5:1 are the address. Clock addresses are 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 day, 6 year, 7 control, 8 trickle.
  - Bit 0 is 1 for a read and 0 for a write.
  - So a clock register is written with 0x80+2·addr and read with 0x81+2·addr.
- R3: Input bits are taken at the serial-clock rising edge, LSB first. Read data is driven after each falling edge, LSB first. `sdo_en_o` is high only while read data is being driven.
- R4: While control bit 7 is 1, writes to every register other than control, and to RAM, have no effect. Control can always be written, and its bits 6:0 read back as 0.
- R5: The trickle register stores all 8 bits. `trickle_en_o` is 1 exactly when trickle bits 7:4 equal 1010.
- R6: While seconds bit 7 is 0, each `tick_i` pulse advances seconds in BCD. 59 rolls to 00 and carries into minutes (same for minutes into hours). While bit 7 is 1, ticks have no effect.
- R7: In 24-hour mode (hours bit 7 = 0, bits 5:0 BCD 00–23), 23:59:59 rolls to 00:00:00 and advances the date. Day of week runs 1–7 and wraps 7→1.
- R8: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, bits 4:0 BCD 01–12):
  - 11 rolls to 12 and toggles PM.
  - 12 rolls to 01 with PM kept.
  - 11 PM→12 AM advances the date.
- R9: Date rollover follows month length:
  - 30 days for months 04, 06, 09, 11.
  - 29 days for month 02 when the BCD year is divisible by 4, and 28 otherwise.
  - 31 days for all other months.
  - Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: Clock burst is address 31 with bit 6 = 0 (0xBE write, 0xBF read).
  - A burst read streams sec, min, hour, date, month, day, year, control, then wraps to sec.
  - A burst write takes those eight bytes and commits them together only when the eighth arrives.
- R11: The RAM holds `RAM_BYTES` bytes (default 31), one per address.
  - Single access uses address 0..`RAM_BYTES`-1 with bit 6 = 1 (0xC0+2·a write, 0xC1+2·a read).
  - RAM burst (0xFE write, 0xFF read) starts at byte 0 and wraps after the last byte.
- R12: Dropping chip enable aborts any transfer and discards a partly shifted byte. The next transfer starts with a fresh command.
- R13: A single-register write completes after one data byte. Further bytes before chip enable drops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples all serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable; high frames a transfer |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| tick_i | input | 1 | One-cycle pulse that advances the calendar by one second |
| sdo_o | output | 1 | Serial read data |
| sdo_en_o | output | 1 | High while `sdo_o` carries read data |
| trickle_en_o | output | 1 | Trickle-charge enable decoded from the trickle register |

## Verification
The calendar is started from chosen instants that separate the carry paths:
- a plain seconds step;
- a minute carry;
- midnight in 24-hour mode;
- the 11→12 and 12→01 steps, and PM midnight, in 12-hour mode;
- ends of 30-day, 31-day, leap and non-leap February months;
- the year-99 rollover.

Serial access is tried as single reads and writes, an ignored command, a write with surplus bytes, a truncated burst, bursts that run past their region to show wrap-around, and a half-shifted byte cut off by chip enable. A trickle value that is not a bit palindrome shows the bit order. Writes made with the lock set, and writes to the lock itself, show what the lock guards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NREG     = 9;
    localparam int IDX_CTRL = 7;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_DONE
    } phase_e;

    // one step of a two-digit BCD counter, no wrap handling
    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_sclk_edges.sv
module rtc_sclk_edges (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sclk_q <= 1'b0;
        else         sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  logic [6:0][7:0] now_i,
    output logic [6:0][7:0] next_o
);
    byte_t      s_inc, m_inc, h12_inc, h24_inc, d_inc, mo_inc, y_inc, wd_inc, last_day;
    logic       sec_w, min_w, day_w, pm, leap;
    logic [4:0] h12;
    logic [1:0] lsum;

    always_comb begin
        next_o  = now_i;
        s_inc   = bcd_inc({1'b0, now_i[0][6:0]});
        m_inc   = bcd_inc(now_i[1]);
        h12_inc = bcd_inc({3'b000, now_i[2][4:0]});
        h24_inc = bcd_inc({2'b00, now_i[2][5:0]});
        d_inc   = bcd_inc(now_i[3]);
        mo_inc  = bcd_inc(now_i[4]);
        wd_inc  = bcd_inc(now_i[5]);
        y_inc   = bcd_inc(now_i[6]);
        // (10T + O) mod 4 == (2T + O) mod 4
        lsum    = {now_i[6][4], 1'b0} + now_i[6][1:0];
        leap    = (lsum == 2'b00);
        case (now_i[4])
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase

        sec_w = (now_i[0][6:0] == 7'h59);
        min_w = sec_w && (now_i[1] == 8'h59);
        day_w = 1'b0;
        pm    = now_i[2][5];
        h12   = h12_inc[4:0];

        next_o[0] = {now_i[0][7], sec_w ? 7'h00 : s_inc[6:0]};
        if (sec_w) next_o[1] = min_w ? 8'h00 : m_inc;

        if (min_w) begin
            if (now_i[2][7]) begin
                if (now_i[2][4:0] == 5'h12) begin
                    h12 = 5'h01;
                end else if (now_i[2][4:0] == 5'h11) begin
                    h12   = 5'h12;
                    pm    = ~now_i[2][5];
                    day_w = now_i[2][5];
                end
                next_o[2] = {1'b1, 1'b0, pm, h12};
            end else if (now_i[2][6:0] == 7'h23) begin
                next_o[2] = 8'h00;
                day_w     = 1'b1;
            end else begin
                next_o[2] = h24_inc;
            end
        end

        if (day_w) begin
            next_o[5] = (now_i[5] == 8'h07) ? 8'h01 : wd_inc;
            if (now_i[3] == last_day) begin
                next_o[3] = 8'h01;
                if (now_i[4] == 8'h12) begin
                    next_o[4] = 8'h01;
                    next_o[6] = (now_i[6] == 8'h99) ? 8'h00 : y_inc;
                end else begin
                    next_o[4] = mo_inc;
                end
            end else begin
                next_o[3] = d_inc;
            end
        end
    end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter int RAM_BYTES = 31
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic tick_i,
    output logic sdo_o,
    output logic sdo_en_o,
    output logic trickle_en_o
);
    localparam int RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam logic [4:0] RAM_LAST = 5'(RAM_BYTES - 1);
    localparam logic [NREG-1:0][7:0] REG_INIT =
        {8'h5C, 8'h80, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80};

    typedef struct packed {
        logic [NREG-1:0][7:0]      regs;
        logic [RAM_BYTES-1:0][7:0] ram;
        logic [6:0][7:0]           stage;
        phase_e                    phase;
        logic [2:0]                bit_cnt;
        logic [7:0]                shift;
        logic                      is_ram;
        logic                      burst;
        logic [4:0]                ptr;
        logic                      drive;
        logic                      sdo;
        logic [2:0]                obit;
    } st_t;

    st_t             st_q, st_d, st_rst;
    logic            rise, fall, byte_wr, wp;
    byte_t           new_byte, rd_now, rd_next;
    logic [4:0]      ptr_adv;
    logic [6:0][7:0] cal_next;

    function automatic byte_t pick(input logic [NREG-1:0][7:0] r,
                                   input logic [RAM_BYTES-1:0][7:0] m,
                                   input logic from_ram, input logic [4:0] p);
        pick = 8'h00;
        if (from_ram) begin
            if (int'(p) < RAM_BYTES) pick = m[p[RAM_AW-1:0]];
        end else if (int'(p) < NREG) begin
            pick = r[p[3:0]];
        end
    endfunction

    rtc_sclk_edges u_edges (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sclk_i(sclk_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    rtc_calendar_step u_cal (
        .now_i (st_q.regs[6:0]),
        .next_o(cal_next)
    );

    always_comb begin
        st_rst      = '0;
        st_rst.regs = REG_INIT;
    end

    always_comb begin
        wp       = st_q.regs[IDX_CTRL][7];
        new_byte = {sdi_i, st_q.shift[7:1]};
        if (!st_q.burst)       ptr_adv = st_q.ptr;
        else if (st_q.is_ram)  ptr_adv = (st_q.ptr == RAM_LAST) ? 5'd0 : st_q.ptr + 5'd1;
        else                   ptr_adv = (st_q.ptr == 5'd7) ? 5'd0 : st_q.ptr + 5'd1;
        rd_now  = pick(st_q.regs, st_q.ram, st_q.is_ram, st_q.ptr);
        rd_next = pick(st_q.regs, st_q.ram, st_q.is_ram, ptr_adv);
    end

    always_comb begin
        st_d    = st_q;
        byte_wr = 1'b0;
        if (!ce_i) begin
            st_d.phase   = PH_CMD;
            st_d.bit_cnt = 3'd0;
            st_d.drive   = 1'b0;
            st_d.sdo     = 1'b0;
            st_d.obit    = 3'd0;
        end else begin
            if (rise && (st_q.phase == PH_CMD || st_q.phase == PH_WR)) begin
                st_d.shift   = new_byte;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    if (st_q.phase == PH_CMD) begin
                        if (!new_byte[7]) begin
                            st_d.phase = PH_DONE;
                        end else begin
                            st_d.is_ram = new_byte[6];
                            st_d.burst  = (new_byte[5:1] == 5'h1F);
                            st_d.ptr    = (new_byte[5:1] == 5'h1F) ? 5'd0 : new_byte[5:1];
                            st_d.phase  = new_byte[0] ? PH_RD : PH_WR;
                        end
                    end else begin
                        byte_wr = 1'b1;
                        if (!st_q.burst) begin
                            st_d.phase = PH_DONE;
                            if (st_q.is_ram) begin
                                if (!wp && int'(st_q.ptr) < RAM_BYTES)
                                    st_d.ram[st_q.ptr[RAM_AW-1:0]] = new_byte;
                            end else if (st_q.ptr == 5'(IDX_CTRL)) begin
                                st_d.regs[IDX_CTRL] = {new_byte[7], 7'b0};
                            end else if (!wp && int'(st_q.ptr) < NREG) begin
                                st_d.regs[st_q.ptr[3:0]] = new_byte;
                            end
                        end else if (st_q.is_ram) begin
                            if (!wp) st_d.ram[st_q.ptr[RAM_AW-1:0]] = new_byte;
                            st_d.ptr = ptr_adv;
                        end else if (st_q.ptr == 5'd7) begin
                            st_d.phase = PH_DONE;
                            if (!wp) begin
                                st_d.regs[6:0]      = st_q.stage;
                                st_d.regs[IDX_CTRL] = {new_byte[7], 7'b0};
                            end
                        end else begin
                            st_d.stage[st_q.ptr[2:0]] = new_byte;
                            st_d.ptr                  = ptr_adv;
                        end
                    end
                end
            end
            if (fall && st_q.phase == PH_RD) begin
                if (!st_q.drive) begin
                    st_d.drive = 1'b1;
                    st_d.obit  = 3'd0;
                    st_d.sdo   = rd_now[0];
                end else if (st_q.obit == 3'd7) begin
                    st_d.ptr  = ptr_adv;
                    st_d.obit = 3'd0;
                    st_d.sdo  = rd_next[0];
                end else begin
                    st_d.obit = st_q.obit + 3'd1;
                    st_d.sdo  = rd_now[st_q.obit + 3'd1];
                end
            end
        end
        // a tick that coincides with a written byte is dropped
        if (tick_i && !st_q.regs[0][7] && !byte_wr) st_d.regs[6:0] = cal_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= st_rst;
        else         st_q <= st_d;
    end

    assign sdo_o        = st_q.sdo;
    assign sdo_en_o     = st_q.drive;
    assign trickle_en_o = (st_q.regs[8][7:4] == 4'b1010);

    assert_lock_guards_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.regs[IDX_CTRL][7] && !tick_i) |=>
            ($stable(st_q.regs[6:1]) && $stable(st_q.regs[8]) && $stable(st_q.ram)));

    assert_trickle_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(trickle_en_o) |-> $past(byte_wr));

    assert_halt_freezes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.regs[0][7] && !byte_wr) |=> $stable(st_q.regs[6:0]));

    assert_ce_drop_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_i |=> (st_q.phase == PH_CMD && st_q.bit_cnt == 3'd0 && !sdo_en_o));
endmodule

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
    logic sdo, sdo_en, trickle_en;
    int   n_checks = 0, n_err = 0;
    bit   finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_serial_slave dut (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .tick_i(tick), .sdo_o(sdo), .sdo_en_o(sdo_en), .trickle_en_o(trickle_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    // monitor: compares captured read bytes against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_x();
        ce = 1'b1;
        wait_clk(2);
    endtask

    task automatic close_x();
        ce   = 1'b0;
        sclk = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdi  = b[i];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic send(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic recv(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            b[i] = sdo;
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic expect_byte(input logic [7:0] got, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        act_q.push_back(got);
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] data);
        open_x();
        send(cmd);
        send(data);
        close_x();
    endtask

    task automatic rd(input logic [7:0] cmd, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        open_x();
        send(cmd);
        recv(b);
        close_x();
        expect_byte(b, exp, tag);
    endtask

    task automatic bw(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] wd,
                      input logic [7:0] yr);
        open_x();
        send(8'hBE);
        send(s); send(m); send(h); send(dt); send(mo); send(wd); send(yr); send(8'h00);
        close_x();
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        wait_clk(1);
        tick = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        logic [7:0] b;
        logic [7:0] exp_burst[9];

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        check("R1 sdo_en", int'(sdo_en), 0);
        check("R1 trickle_en", int'(trickle_en), 0);
        rd(8'h8F, 8'h80, "R1 control");
        rd(8'h81, 8'h80, "R1 seconds");
        rd(8'h91, 8'h5C, "R1 trickle");
        rd(8'h87, 8'h01, "R1 date");
        rd(8'h89, 8'h01, "R1 month");
        rd(8'h8B, 8'h01, "R1 weekday");
        rd(8'h83, 8'h00, "R1 minutes");

        // R4 lock blocks writes
        wr(8'h82, 8'h45);
        rd(8'h83, 8'h00, "R4 locked minute write");
        wr(8'hC0, 8'hAA);
        rd(8'hC1, 8'h00, "R4 locked ram write");
        wr(8'h90, 8'hA3);
        check("R4 locked trickle write", int'(trickle_en), 0);
        wr(8'h8E, 8'h00);
        rd(8'h8F, 8'h00, "R4 unlock control");

        // R2 command decode
        wr(8'h82, 8'h45);
        rd(8'h83, 8'h45, "R2 minute write/read");
        wr(8'h02, 8'h33);
        rd(8'h83, 8'h45, "R2 command with bit7 clear ignored");

        // R13 surplus bytes after a single write
        open_x();
        send(8'h82); send(8'h12); send(8'h34);
        close_x();
        rd(8'h83, 8'h12, "R13 surplus byte ignored");

        // R5 and R3: trickle decode, bit order, output enable
        wr(8'h90, 8'hA3);
        check("R5 trickle_en on 1010", int'(trickle_en), 1);
        open_x();
        send(8'h91);
        check("R3 sdo_en while reading", int'(sdo_en), 1);
        recv(b);
        close_x();
        expect_byte(b, 8'hA3, "R3 LSB-first read of trickle");
        check("R3 sdo_en after ce drop", int'(sdo_en), 0);
        wr(8'h90, 8'h5A);
        check("R5 trickle_en off 0101", int'(trickle_en), 0);
        rd(8'h91, 8'h5A, "R5 trickle stores all bits");

        // R6 seconds counting and halt
        wr(8'h80, 8'h58);
        pulse_tick();
        rd(8'h81, 8'h59, "R6 one tick");
        wr(8'h80, 8'h85);
        pulse_tick(); pulse_tick(); pulse_tick();
        rd(8'h81, 8'h85, "R6 halted clock ignores ticks");
        wr(8'h82, 8'h10);
        wr(8'h80, 8'h59);
        pulse_tick();
        rd(8'h81, 8'h00, "R6 seconds wrap");
        rd(8'h83, 8'h11, "R6 minute carry");

        // R7 + R10: midnight 24h, month end, burst read wrap
        bw(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h07, 8'h24);
        pulse_tick();
        exp_burst = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h01, 8'h24, 8'h00, 8'h00};
        open_x();
        send(8'hBF);
        for (int i = 0; i < 9; i++) begin
            recv(b);
            expect_byte(b, exp_burst[i], $sformatf("R7 R10 burst byte %0d", i));
        end
        close_x();

        // R9 month lengths
        bw(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h24);
        pulse_tick();
        rd(8'h87, 8'h29, "R9 leap february date");
        rd(8'h89, 8'h02, "R9 leap february month");
        bw(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h23);
        pulse_tick();
        rd(8'h87, 8'h01, "R9 plain february date");
        rd(8'h89, 8'h03, "R9 plain february month");
        bw(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h03, 8'h23);
        pulse_tick();
        rd(8'h87, 8'h01, "R9 30-day month date");
        rd(8'h89, 8'h05, "R9 30-day month month");
        bw(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h03, 8'h99);
        pulse_tick();
        rd(8'h87, 8'h01, "R9 year end date");
        rd(8'h89, 8'h01, "R9 year end month");
        rd(8'h8D, 8'h00, "R9 year 99 wraps");

        // R8 12-hour mode
        bw(8'h59, 8'h59, 8'h91, 8'h05, 8'h03, 8'h02, 8'h24);
        pulse_tick();
        rd(8'h85, 8'hB2, "R8 11AM to 12PM");
        rd(8'h87, 8'h05, "R8 noon keeps date");
        bw(8'h59, 8'h59, 8'hB2, 8'h05, 8'h03, 8'h02, 8'h24);
        pulse_tick();
        rd(8'h85, 8'hA1, "R8 12PM to 1PM");
        bw(8'h59, 8'h59, 8'hB1, 8'h05, 8'h03, 8'h02, 8'h24);
        pulse_tick();
        rd(8'h85, 8'h92, "R8 11PM to 12AM");
        rd(8'h87, 8'h06, "R8 PM midnight advances date");
        rd(8'h8B, 8'h03, "R8 PM midnight advances weekday");

        // R10 truncated burst write commits nothing
        open_x();
        send(8'hBE);
        send(8'h33); send(8'h33); send(8'h33);
        close_x();
        rd(8'h81, 8'h00, "R10 truncated burst seconds");
        rd(8'h85, 8'h92, "R10 truncated burst hours");

        // R11 RAM single and burst
        wr(8'hCA, 8'h3C);
        rd(8'hCB, 8'h3C, "R11 ram single");
        open_x();
        send(8'hFE);
        for (int i = 0; i < 31; i++) send(8'(i * 3 + 1));
        send(8'hEE);
        close_x();
        open_x();
        send(8'hFF);
        for (int i = 0; i < 32; i++) begin
            recv(b);
            expect_byte(b, (i == 0 || i == 31) ? 8'hEE : 8'(i * 3 + 1),
                        $sformatf("R11 ram burst byte %0d", i));
        end
        close_x();

        // R12 abort mid-byte
        open_x();
        send_bits(8'h82, 4);
        close_x();
        wr(8'h82, 8'h27);
        rd(8'h83, 8'h27, "R12 fresh command after abort");

        // R4 lock re-armed, low control bits read as zero
        wr(8'h8E, 8'hFF);
        rd(8'h8F, 8'h80, "R4 control low bits zero");
        wr(8'h82, 8'h55);
        rd(8'h83, 8'h27, "R4 locked again");

        wait_clk(4);
        if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule